// File: doc/BRIEF.md
# Branch and Jump Target Unit

This unit chooses the next program counter for a 16-bit processor whose memory is addressed in 16-bit words, so the counter spans 64k word addresses. Each cycle it takes the current PC, a two-bit control-transfer class, a 4-bit condition selector and the five stored status flags (carry, overflow, unsigned-lower, signed-negative and zero). For a branch it adds a signed 8-bit word displacement to the current PC. For a jump it takes the absolute target from a register operand. For a jump-and-link it redirects to the register target and also produces the return address, with a write strobe for the register file. A return is not a separate operation: it is an unconditional jump through the register that holds the saved link.

All decisions are registered. The result computed from the inputs seen at one rising clock edge shows up on the outputs just after that edge, and it stays there until the next edge. Reset is asserted asynchronously and released through a two-stage synchronizer. After reset the outputs sit at zero until the first edge that follows the synchronizer.

Top module: `bju_next_pc`

## Requirements
- R1: While reset is active, next_pc_o, link_o, taken_o and link_we_o are all zero.
- R2: The outputs are registered. The values after a rising edge depend only on the inputs sampled at that edge, and they hold until the next edge.
- R3: Class 2'b00 (no transfer) gives next_pc_o = pc_i + 1 with taken_o and link_we_o low, whatever the condition and flags are.
- R4: Class 2'b01 (branch) with a true condition gives next_pc_o = pc_i + sign-extended disp_i, modulo 2^16, with taken_o high.
- R5: Class 2'b10 (jump) with a true condition gives next_pc_o = tgt_i with taken_o high. A return is this case with the saved link register as tgt_i and the always condition.
- R6: Branch or jump with a false condition gives next_pc_o = pc_i + 1 with taken_o low.
- R7: The flags form flags_i = {Z[4], N[3], L[2], F[1], C[0]}. Each condition code tests the flags as follows: 0 Z=1, 1 Z=0, 2 C=1, 3 C=0, 4 L=1, 5 L=0, 6 N=1, 7 N=0, 8 F=1, 9 F=0, 10 L=0 and Z=0, 11 L=1 or Z=1, 12 N=0 and Z=0, 13 N=1 or Z=1.
- R8: Condition code 14 is always true, whatever the flags. Condition code 15 is never true, even when all five flags are set.
- R9: Class 2'b11 (jump-and-link) ignores the condition. In the same output cycle it gives next_pc_o = tgt_i, taken_o high, link_we_o high and link_o = pc_i + 1 modulo 2^16.
- R10: link_we_o is low for every class other than jump-and-link.
- R11: The sequential increment wraps, so pc_i = 16'hFFFF without a taken transfer yields next_pc_o = 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cls_i | input | 2 | Transfer class: 00 none, 01 branch, 10 jump, 11 jump-and-link |
| cond_i | input | 4 | Condition selector |
| flags_i | input | 5 | Stored flags {Z,N,L,F,C} |
| disp_i | input | 8 | Signed branch displacement in words |
| pc_i | input | 16 | Current program counter |
| tgt_i | input | 16 | Register target value for jumps |
| next_pc_o | output | 16 | Registered next program counter |
| taken_o | output | 1 | Registered transfer-taken indication |
| link_o | output | 16 | Registered return address |
| link_we_o | output | 1 | Registered link write strobe |

## Verification
The assertions assume that every input is a known value at each rising edge once the synchronized reset has been released. They also measure the one-cycle relation from the synchronized reset, not from the raw pin. To stay inside these assumptions, the bench changes inputs only on falling edges, and it waits several cycles after releasing reset before it applies the first vector. The bench keeps the input class at 2'b00 when it asserts reset in the middle of a run, so every sampled edge carries a defined class.

// File: rtl/bju_pkg.sv
package bju_pkg;

  typedef enum logic [1:0] {
    XFER_NONE = 2'b00,
    XFER_BR   = 2'b01,
    XFER_JMP  = 2'b10,
    XFER_JAL  = 2'b11
  } xfer_cls_e;

  typedef enum logic [3:0] {
    CC_ZSET  = 4'd0,
    CC_ZCLR  = 4'd1,
    CC_CSET  = 4'd2,
    CC_CCLR  = 4'd3,
    CC_LSET  = 4'd4,
    CC_LCLR  = 4'd5,
    CC_NSET  = 4'd6,
    CC_NCLR  = 4'd7,
    CC_FSET  = 4'd8,
    CC_FCLR  = 4'd9,
    CC_NLNZ  = 4'd10,
    CC_LORZ  = 4'd11,
    CC_NNNZ  = 4'd12,
    CC_NORZ  = 4'd13,
    CC_ALWAYS = 4'd14,
    CC_NEVER = 4'd15
  } cond_sel_e;

  typedef struct packed {
    logic z;
    logic n;
    logic l;
    logic f;
    logic c;
  } stat_flags_t;

  localparam int unsigned FLAG_W = $bits(stat_flags_t);

endpackage

// File: rtl/bju_rst_sync.sv
module bju_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/bju_cond_eval.sv
module bju_cond_eval
  import bju_pkg::*;
(
  input  logic [3:0]           cond_i,
  input  logic [FLAG_W-1:0]    flags_i,
  output logic                 pass_o
);

  stat_flags_t fl;

  always_comb begin
    fl = stat_flags_t'(flags_i);
    unique case (cond_sel_e'(cond_i))
      CC_ZSET:   pass_o = fl.z;
      CC_ZCLR:   pass_o = ~fl.z;
      CC_CSET:   pass_o = fl.c;
      CC_CCLR:   pass_o = ~fl.c;
      CC_LSET:   pass_o = fl.l;
      CC_LCLR:   pass_o = ~fl.l;
      CC_NSET:   pass_o = fl.n;
      CC_NCLR:   pass_o = ~fl.n;
      CC_FSET:   pass_o = fl.f;
      CC_FCLR:   pass_o = ~fl.f;
      CC_NLNZ:   pass_o = ~fl.l & ~fl.z;
      CC_LORZ:   pass_o = fl.l | fl.z;
      CC_NNNZ:   pass_o = ~fl.n & ~fl.z;
      CC_NORZ:   pass_o = fl.n | fl.z;
      CC_ALWAYS: pass_o = 1'b1;
      CC_NEVER:  pass_o = 1'b0;
      default:   pass_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/bju_target_calc.sv
module bju_target_calc #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] disp_i,
  output logic [AW-1:0] seq_pc_o,
  output logic [AW-1:0] rel_pc_o
);

  localparam int unsigned EXT_W = AW - DW;

  logic [AW-1:0] disp_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp_ext = {{EXT_W{disp_i[DW-1]}}, disp_i};
    end else begin : g_noext
      assign disp_ext = disp_i[AW-1:0];
    end
  endgenerate

  always_comb begin
    seq_pc_o = pc_i + {{(AW-1){1'b0}}, 1'b1};
    rel_pc_o = pc_i + disp_ext;
  end

endmodule

// File: rtl/bju_next_pc.sv
module bju_next_pc
  import bju_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         cls_i,
  input  logic [3:0]         cond_i,
  input  logic [FLAG_W-1:0]  flags_i,
  input  logic [DW-1:0]      disp_i,
  input  logic [AW-1:0]      pc_i,
  input  logic [AW-1:0]      tgt_i,
  output logic [AW-1:0]      next_pc_o,
  output logic               taken_o,
  output logic [AW-1:0]      link_o,
  output logic               link_we_o
);

  logic          rst_q_n;
  logic          cond_pass;
  logic [AW-1:0] seq_pc;
  logic [AW-1:0] rel_pc;

  logic [AW-1:0] next_pc_d, next_pc_q;
  logic          taken_d, taken_q;
  logic [AW-1:0] link_d, link_q;
  logic          link_we_d, link_we_q;

  bju_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_q_n)
  );

  bju_cond_eval u_cond (
    .cond_i  (cond_i),
    .flags_i (flags_i),
    .pass_o  (cond_pass)
  );

  bju_target_calc #(.AW(AW), .DW(DW)) u_tgt (
    .pc_i     (pc_i),
    .disp_i   (disp_i),
    .seq_pc_o (seq_pc),
    .rel_pc_o (rel_pc)
  );

  // next-state selection
  always_comb begin
    next_pc_d = seq_pc;
    taken_d   = 1'b0;
    link_d    = seq_pc;
    link_we_d = 1'b0;
    unique case (xfer_cls_e'(cls_i))
      XFER_BR: begin
        if (cond_pass) begin
          next_pc_d = rel_pc;
          taken_d   = 1'b1;
        end
      end
      XFER_JMP: begin
        if (cond_pass) begin
          next_pc_d = tgt_i;
          taken_d   = 1'b1;
        end
      end
      XFER_JAL: begin
        next_pc_d = tgt_i;
        taken_d   = 1'b1;
        link_we_d = 1'b1;
      end
      default: begin
        next_pc_d = seq_pc;
      end
    endcase
  end

  // output registers
  always_ff @(posedge clk_i or negedge rst_q_n) begin
    if (!rst_q_n) begin
      next_pc_q <= '0;
      taken_q   <= 1'b0;
      link_q    <= '0;
      link_we_q <= 1'b0;
    end else begin
      next_pc_q <= next_pc_d;
      taken_q   <= taken_d;
      link_q    <= link_d;
      link_we_q <= link_we_d;
    end
  end

  assign next_pc_o = next_pc_q;
  assign taken_o   = taken_q;
  assign link_o    = link_q;
  assign link_we_o = link_we_q;

endmodule

// File: rtl/bju_next_pc_chk.sv
module bju_next_pc_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_n,
  input logic [1:0]    cls_i,
  input logic [3:0]    cond_i,
  input logic [AW-1:0] pc_i,
  input logic [AW-1:0] tgt_i,
  input logic [AW-1:0] next_pc_o,
  input logic          taken_o,
  input logic [AW-1:0] link_o,
  input logic          link_we_o
);

  // R3
  none_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cls_i == 2'b00) |=> (!taken_o && !link_we_o && next_pc_o == $past(pc_i) + 1'b1));

  // R9
  jal_link_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cls_i == 2'b11) |=> (taken_o && link_we_o && next_pc_o == $past(tgt_i)
                          && link_o == $past(pc_i) + 1'b1));

  // R10
  link_only_jal_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cls_i != 2'b11) |=> !link_we_o);

  // R8
  never_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cls_i inside {2'b01, 2'b10} && cond_i == 4'd15) |=> !taken_o);

  // R5
  uncond_jump_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cls_i == 2'b10 && cond_i == 4'd14) |=> (taken_o && next_pc_o == $past(tgt_i)));

  // R6
  fallthrough_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cls_i inside {2'b01, 2'b10}) |=> (taken_o || next_pc_o == $past(pc_i) + 1'b1));

endmodule

bind bju_next_pc bju_next_pc_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_q_n),
  .cls_i     (cls_i),
  .cond_i    (cond_i),
  .pc_i      (pc_i),
  .tgt_i     (tgt_i),
  .next_pc_o (next_pc_o),
  .taken_o   (taken_o),
  .link_o    (link_o),
  .link_we_o (link_we_o)
);

// File: tb/sim_bju_next_pc.sv
module sim_bju_next_pc;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 25;

  typedef struct packed {
    logic [1:0]  cls;
    logic [3:0]  cond;
    logic [4:0]  flags;
    logic [7:0]  disp;
    logic [15:0] pc;
    logic [15:0] tgt;
    logic [15:0] exp_pc;
    logic        exp_tk;
    logic        exp_we;
  } vec_t;

  // flags = {Z,N,L,F,C}
  localparam vec_t VECS [NVEC] = '{
    '{2'b01, 4'd0,  5'b10000, 8'h05, 16'h0010, 16'h0000, 16'h0015, 1'b1, 1'b0}, // R4 R7
    '{2'b01, 4'd0,  5'b00000, 8'h05, 16'h0010, 16'h0000, 16'h0011, 1'b0, 1'b0}, // R6
    '{2'b01, 4'd1,  5'b00000, 8'hFE, 16'h0100, 16'h0000, 16'h00FE, 1'b1, 1'b0}, // R4
    '{2'b01, 4'd2,  5'b00001, 8'h7F, 16'h1000, 16'h0000, 16'h107F, 1'b1, 1'b0}, // R7
    '{2'b01, 4'd3,  5'b00001, 8'h7F, 16'h1000, 16'h0000, 16'h1001, 1'b0, 1'b0}, // R7
    '{2'b01, 4'd4,  5'b00100, 8'h80, 16'h0000, 16'h0000, 16'hFF80, 1'b1, 1'b0}, // R4 wrap
    '{2'b01, 4'd5,  5'b00000, 8'h01, 16'hFFFF, 16'h0000, 16'h0000, 1'b1, 1'b0}, // R4 wrap
    '{2'b01, 4'd6,  5'b01000, 8'h10, 16'h2000, 16'h0000, 16'h2010, 1'b1, 1'b0}, // R7
    '{2'b01, 4'd7,  5'b01000, 8'h10, 16'h2000, 16'h0000, 16'h2001, 1'b0, 1'b0}, // R7
    '{2'b10, 4'd8,  5'b00010, 8'h00, 16'h0050, 16'hABCD, 16'hABCD, 1'b1, 1'b0}, // R5
    '{2'b10, 4'd9,  5'b00010, 8'h00, 16'h0050, 16'hABCD, 16'h0051, 1'b0, 1'b0}, // R6
    '{2'b10, 4'd10, 5'b00000, 8'h00, 16'h0000, 16'h1234, 16'h1234, 1'b1, 1'b0}, // R7
    '{2'b10, 4'd10, 5'b10000, 8'h00, 16'h0000, 16'h1234, 16'h0001, 1'b0, 1'b0}, // R7
    '{2'b10, 4'd11, 5'b10000, 8'h00, 16'h0007, 16'h4000, 16'h4000, 1'b1, 1'b0}, // R7
    '{2'b10, 4'd11, 5'b00000, 8'h00, 16'h0007, 16'h4000, 16'h0008, 1'b0, 1'b0}, // R7
    '{2'b01, 4'd12, 5'b00000, 8'h03, 16'h0300, 16'h0000, 16'h0303, 1'b1, 1'b0}, // R7
    '{2'b01, 4'd12, 5'b01000, 8'h03, 16'h0300, 16'h0000, 16'h0301, 1'b0, 1'b0}, // R7
    '{2'b01, 4'd13, 5'b01000, 8'hFD, 16'h0300, 16'h0000, 16'h02FD, 1'b1, 1'b0}, // R7
    '{2'b10, 4'd13, 5'b00000, 8'h00, 16'h0AAA, 16'h9999, 16'h0AAB, 1'b0, 1'b0}, // R7
    '{2'b10, 4'd14, 5'b00000, 8'h00, 16'h0001, 16'h8000, 16'h8000, 1'b1, 1'b0}, // R8 R5
    '{2'b01, 4'd15, 5'b11111, 8'h05, 16'h0001, 16'h0000, 16'h0002, 1'b0, 1'b0}, // R8
    '{2'b11, 4'd15, 5'b00000, 8'h00, 16'h0123, 16'hC000, 16'hC000, 1'b1, 1'b1}, // R9
    '{2'b11, 4'd0,  5'b00000, 8'h00, 16'hFFFF, 16'h0000, 16'h0000, 1'b1, 1'b1}, // R9
    '{2'b00, 4'd14, 5'b11111, 8'h7F, 16'hFFFF, 16'h5555, 16'h0000, 1'b0, 1'b0}, // R3 R11
    '{2'b00, 4'd0,  5'b10000, 8'h05, 16'h0040, 16'h0000, 16'h0041, 1'b0, 1'b0}  // R3 R10
  };

  logic        clk;
  logic        rst_n;
  logic [1:0]  cls;
  logic [3:0]  cond;
  logic [4:0]  flags;
  logic [7:0]  disp;
  logic [15:0] pc;
  logic [15:0] tgt;
  logic [15:0] next_pc;
  logic        taken;
  logic [15:0] link;
  logic        link_we;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  bju_next_pc u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .cls_i     (cls),
    .cond_i    (cond),
    .flags_i   (flags),
    .disp_i    (disp),
    .pc_i      (pc),
    .tgt_i     (tgt),
    .next_pc_o (next_pc),
    .taken_o   (taken),
    .link_o    (link),
    .link_we_o (link_we)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    cls   = v.cls;
    cond  = v.cond;
    flags = v.flags;
    disp  = v.disp;
    pc    = v.pc;
    tgt   = v.tgt;
  endtask

  initial begin
    rst_n = 1'b0;
    cls = 2'b00; cond = 4'd0; flags = '0; disp = '0; pc = 16'h0005; tgt = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 next_pc", next_pc, 16'h0000);
    chk("R1 taken", {15'd0, taken}, 16'd0);
    chk("R1 link", link, 16'h0000);
    chk("R1 link_we", {15'd0, link_we}, 16'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      chk($sformatf("R2 vec%0d next_pc", i), next_pc, VECS[i].exp_pc);
      chk($sformatf("R6 vec%0d taken", i), {15'd0, taken}, {15'd0, VECS[i].exp_tk});
      chk($sformatf("R10 vec%0d link_we", i), {15'd0, link_we}, {15'd0, VECS[i].exp_we});
      if (VECS[i].exp_we)
        chk($sformatf("R9 vec%0d link", i), link, VECS[i].pc + 16'd1);
    end

    // R2: outputs hold until the next edge
    drive(VECS[19]);
    @(negedge clk);
    cls = 2'b00; pc = 16'h0777;
    #(CLK_PERIOD/4);
    chk("R2 hold before edge", next_pc, 16'h8000);
    @(negedge clk);
    chk("R2 update after edge", next_pc, 16'h0778);

    // R5: return through link value
    drive(VECS[21]);
    @(negedge clk);
    cls = 2'b10; cond = 4'd14; tgt = link; pc = 16'hC005;
    @(negedge clk);
    chk("R5 return to link", next_pc, 16'h0124);

    // R1: asynchronous reset mid-run
    drive(VECS[22]);
    @(negedge clk);
    cls = 2'b00;
    rst_n = 1'b0;
    #1;
    chk("R1 async next_pc", next_pc, 16'h0000);
    chk("R1 async link_we", {15'd0, link_we}, 16'd0);
    chk("R1 async taken", {15'd0, taken}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11: wrap with failing condition
    cls = 2'b10; cond = 4'd15; pc = 16'hFFFF; tgt = 16'h1111;
    @(negedge clk);
    chk("R11 wrap", next_pc, 16'h0000);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule